// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This block forms the second operand of an ALU. It takes a 32-bit operand and a shift kind. It then shifts or rotates the operand by an amount taken from one of two sources. In the first, the amount is packed into the instruction as a 5-bit field. In the second, the amount is read from a register, and the low 8 bits are used. The block also produces the shifter carry-out that a flag-setting instruction would record. It is purely combinational. The ALU adds, compares or moves the result in the same cycle, and the carry-out sits next to the arithmetic carry for the flag logic to pick from.

The two amount sources differ at the edges. In the packed form, a zero field is not always a null shift. It stands for a full-width shift in the two right shifts, and for a one-bit rotate through the carry in the rotate kind. In the register form, a zero amount always passes the operand through and keeps the incoming carry. Amounts at or beyond the word width have fixed results in this form.

Top module: `shf_operand_unit`

## Requirements
- R1: `kind_i` is encoded 00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right. `imm_mode_i`=1 selects the packed amount n=`amt_i[4:0]`, and 0 selects the register amount n=`amt_i[7:0]`. For a packed left shift, n=0 gives the operand unchanged with carry-out equal to `carry_i`. Any other n gives operand<<n with carry-out equal to operand bit 32-n.
- R2: With a packed amount n in 1..31, the logical right shift, arithmetic right shift and rotate give their usual results. The carry-out is operand bit n-1.
- R3: A packed logical right shift with n=0 acts as a shift by 32. The result is zero and the carry-out is operand bit 31.
- R4: A packed arithmetic right shift with n=0 gives every result bit equal to operand bit 31. The carry-out is also operand bit 31.
- R5: A packed rotate with n=0 gives `carry_i` in bit 31 and operand bits 31..1 in bits 30..0. The carry-out is operand bit 0.
- R6: In packed mode, `amt_i[7:5]` has no effect on either output.
- R7: In register mode, an amount of 0 gives the operand unchanged and carry-out equal to `carry_i`, for all four kinds.
- R8: In register mode, a shift left or either right shift by n in 1..31 gives the usual result. The carry-out is bit 32-n for the left shift and bit n-1 for the right shifts.
- R9: In register mode, a left shift by exactly 32 gives zero with carry-out equal to operand bit 0. A logical right shift by exactly 32 gives zero with carry-out equal to operand bit 31.
- R10: In register mode, a left shift or logical right shift by 33..255 gives zero with carry-out 0.
- R11: In register mode, an arithmetic right shift by 32..255 fills the result with operand bit 31. The carry-out is operand bit 31.
- R12: In register mode, the rotate uses n mod 32, and a nonzero m=n mod 32 gives carry-out equal to bit m-1. A nonzero n with m=0 gives the operand unchanged with carry-out equal to operand bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Value to shift |
| kind_i | input | 2 | Shift kind (R1 encoding) |
| imm_mode_i | input | 1 | 1: packed 5-bit amount, 0: register amount |
| amt_i | input | 8 | Shift amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The sweep covers every kind, both amount sources and both carry-in values. It runs each packed amount 0..31 and each register amount 0..255 over eight operands. The operands include all-zero, all-one, sign-only and alternating patterns, so a wrong fill bit or a wrong carry bit index changes the output. Packed amounts with nonzero upper bits separate a decoder that ignores bits 7:5 from one that leaks them into the shift. Register amounts 32, 33, 64 and 255 separate exact-width handling from beyond-width handling and from a plain mod-32 wrap. The carry-in toggle separates the pass-through and rotate-through-carry cases from those that ignore the flag.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHF_LSL = 2'b00,
    SHF_LSR = 2'b01,
    SHF_ASR = 2'b10,
    SHF_ROR = 2'b11
  } shf_kind_e;
endpackage

// File: rtl/shf_amt_norm.sv
// Folds both amount sources into a distance mod WIDTH plus case flags.
module shf_amt_norm
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int REG_W = 8,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  shf_kind_e        kind_i,
  input  logic             imm_mode_i,
  input  logic [REG_W-1:0] amt_i,
  output logic [LOG_W-1:0] k_o,
  output logic             pass_o,
  output logic             rrx_o,
  output logic             wrap_o,
  output logic             full_o,
  output logic             over_o
);
  logic [LOG_W-1:0] imm_amt;
  logic             imm_zero, reg_zero, reg_eq, reg_gt, low_zero;

  assign imm_amt  = amt_i[LOG_W-1:0];
  assign imm_zero = (imm_amt == '0);
  assign reg_zero = (amt_i == '0);
  assign reg_eq   = (amt_i == REG_W'(WIDTH));
  assign reg_gt   = (amt_i >  REG_W'(WIDTH));
  assign low_zero = (amt_i[LOG_W-1:0] == '0);

  always_comb begin
    k_o    = amt_i[LOG_W-1:0];
    pass_o = 1'b0;
    rrx_o  = 1'b0;
    wrap_o = 1'b0;
    full_o = 1'b0;
    over_o = 1'b0;
    if (imm_mode_i) begin
      k_o    = imm_amt;
      pass_o = imm_zero && (kind_i == SHF_LSL);
      rrx_o  = imm_zero && (kind_i == SHF_ROR);
      full_o = imm_zero && (kind_i == SHF_LSR || kind_i == SHF_ASR);
    end else begin
      pass_o = reg_zero;
      if (kind_i == SHF_ROR) begin
        wrap_o = !reg_zero && low_zero;
      end else begin
        full_o = reg_eq;
        over_o = reg_gt;
      end
    end
  end
endmodule

// File: rtl/shf_rotator.sv
// Log-depth right rotator.
module shf_rotator #(
  parameter int WIDTH = 32,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [LOG_W-1:0] rot_i,
  output logic [WIDTH-1:0] data_o
);
  logic [LOG_W:0][WIDTH-1:0] st;

  assign st[0] = data_i;
  for (genvar s = 0; s < LOG_W; s++) begin : g_stage
    localparam int D = 2 ** s;
    assign st[s+1] = rot_i[s] ? ((st[s] >> D) | (st[s] << (WIDTH - D))) : st[s];
  end
  assign data_o = st[LOG_W];
endmodule

// File: rtl/shf_finish.sv
// Masks the rotated word into a shift and picks the carry bit.
module shf_finish
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] rot_i,
  input  shf_kind_e        kind_i,
  input  logic [LOG_W-1:0] k_i,
  input  logic             pass_i,
  input  logic             rrx_i,
  input  logic             wrap_i,
  input  logic             full_i,
  input  logic             over_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] ones, mask_l, mask_r, norm_res;
  logic [LOG_W-1:0] cidx;
  logic             sign;

  assign ones   = '1;
  assign mask_l = ones << k_i;
  assign mask_r = ones >> k_i;
  assign sign   = data_i[WIDTH-1];
  assign cidx   = (kind_i == SHF_LSL) ? (LOG_W'(0) - k_i) : (k_i - LOG_W'(1));

  always_comb begin
    unique case (kind_i)
      SHF_LSL: norm_res = rot_i & mask_l;
      SHF_LSR: norm_res = rot_i & mask_r;
      SHF_ASR: norm_res = (rot_i & mask_r) | (sign ? ~mask_r : '0);
      default: norm_res = rot_i;
    endcase
  end

  always_comb begin
    result_o = norm_res;
    carry_o  = data_i[cidx];
    if (pass_i) begin
      result_o = data_i;
      carry_o  = carry_i;
    end else if (rrx_i) begin
      result_o = {carry_i, data_i[WIDTH-1:1]};
      carry_o  = data_i[0];
    end else if (wrap_i) begin
      result_o = data_i;
      carry_o  = sign;
    end else if (full_i || over_i) begin
      unique case (kind_i)
        SHF_LSL: begin result_o = '0; carry_o = full_i & data_i[0]; end
        SHF_LSR: begin result_o = '0; carry_o = full_i & sign; end
        SHF_ASR: begin result_o = {WIDTH{sign}}; carry_o = sign; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/shf_operand_unit.sv
module shf_operand_unit
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int REG_W = 8
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [1:0]       kind_i,
  input  logic             imm_mode_i,
  input  logic [REG_W-1:0] amt_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  localparam int LOG_W = $clog2(WIDTH);

  shf_kind_e        kind;
  logic [LOG_W-1:0] k, rot_amt;
  logic             pass, rrx, wrap, full, over;
  logic [WIDTH-1:0] rotated;

  assign kind = shf_kind_e'(kind_i);

  shf_amt_norm #(.WIDTH(WIDTH), .REG_W(REG_W)) u_norm (
    .kind_i(kind), .imm_mode_i(imm_mode_i), .amt_i(amt_i),
    .k_o(k), .pass_o(pass), .rrx_o(rrx), .wrap_o(wrap),
    .full_o(full), .over_o(over)
  );

  // Left shift k == right rotate by WIDTH-k.
  assign rot_amt = (kind == SHF_LSL) ? (LOG_W'(0) - k) : k;

  shf_rotator #(.WIDTH(WIDTH)) u_rot (
    .data_i(operand_i), .rot_i(rot_amt), .data_o(rotated)
  );

  shf_finish #(.WIDTH(WIDTH)) u_fin (
    .data_i(operand_i), .rot_i(rotated), .kind_i(kind), .k_i(k),
    .pass_i(pass), .rrx_i(rrx), .wrap_i(wrap), .full_i(full),
    .over_i(over), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o)
  );

  always_comb begin
    if (!imm_mode_i && amt_i == '0)
      assert_reg_zero_pass_R7: assert (result_o == operand_i && carry_o == carry_i);
    if (imm_mode_i && kind_i == 2'b01 && amt_i[LOG_W-1:0] == '0)
      assert_lsr_full_R3: assert (result_o == '0 && carry_o == operand_i[WIDTH-1]);
    if (imm_mode_i && kind_i == 2'b11 && amt_i[LOG_W-1:0] == '0)
      assert_rrx_R5: assert (result_o == {carry_i, operand_i[WIDTH-1:1]} && carry_o == operand_i[0]);
    if (!imm_mode_i && !kind_i[1] && amt_i > REG_W'(WIDTH))
      assert_far_zero_R10: assert (result_o == '0 && !carry_o);
    if (!imm_mode_i && kind_i == 2'b10 && amt_i >= REG_W'(WIDTH))
      assert_sign_fill_R11: assert (result_o == {WIDTH{operand_i[WIDTH-1]}} && carry_o == operand_i[WIDTH-1]);
    if (!imm_mode_i && kind_i == 2'b11 && amt_i != '0 && amt_i[LOG_W-1:0] == '0)
      assert_ror_wrap_R12: assert (result_o == operand_i && carry_o == operand_i[WIDTH-1]);
  end
endmodule

// File: tb/sim_shf_operand_unit.sv
module sim_shf_operand_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] operand;
  logic [1:0]  kind;
  logic        imm_mode;
  logic [7:0]  amt;
  logic        cin;
  logic [31:0] result;
  logic        cout;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shf_operand_unit u0 (
    .operand_i(operand), .kind_i(kind), .imm_mode_i(imm_mode),
    .amt_i(amt), .carry_i(cin), .result_o(result), .carry_o(cout)
  );

  function automatic logic [32:0] model(logic [31:0] op, logic [1:0] k,
                                        logic im, logic [7:0] a, logic c);
    int n;
    int m;
    logic [31:0] r;
    logic        co;
    if (im) begin
      n = int'(a[4:0]);
      case (k)
        2'b00: if (n == 0) begin r = op; co = c; end
               else begin r = op << n; co = op[32-n]; end
        2'b01: if (n == 0) begin r = 32'h0; co = op[31]; end
               else begin r = op >> n; co = op[n-1]; end
        2'b10: if (n == 0) begin r = {32{op[31]}}; co = op[31]; end
               else begin r = $signed(op) >>> n; co = op[n-1]; end
        default: if (n == 0) begin r = {c, op[31:1]}; co = op[0]; end
                 else begin r = (op >> n) | (op << (32 - n)); co = op[n-1]; end
      endcase
    end else begin
      n = int'(a);
      if (n == 0) begin r = op; co = c; end
      else case (k)
        2'b00: if (n < 32) begin r = op << n; co = op[32-n]; end
               else begin r = 32'h0; co = (n == 32) ? op[0] : 1'b0; end
        2'b01: if (n < 32) begin r = op >> n; co = op[n-1]; end
               else begin r = 32'h0; co = (n == 32) ? op[31] : 1'b0; end
        2'b10: if (n < 32) begin r = $signed(op) >>> n; co = op[n-1]; end
               else begin r = {32{op[31]}}; co = op[31]; end
        default: begin
          m = n % 32;
          if (m == 0) begin r = op; co = op[31]; end
          else begin r = (op >> m) | (op << (32 - m)); co = op[m-1]; end
        end
      endcase
    end
    return {co, r};
  endfunction

  function automatic string tag(logic [1:0] k, logic im, logic [7:0] a);
    if (im) begin
      if (a[7:5] != 3'b000) return "R6";
      if (k == 2'b00) return "R1";
      if (a[4:0] != 5'd0) return "R2";
      if (k == 2'b01) return "R3";
      if (k == 2'b10) return "R4";
      return "R5";
    end
    if (a == 8'd0) return "R7";
    if (k == 2'b11) return "R12";
    if (a < 8'd32) return "R8";
    if (k == 2'b10) return "R11";
    if (a == 8'd32) return "R9";
    return "R10";
  endfunction

  task automatic apply(logic [31:0] op, logic [1:0] k, logic im, logic [7:0] a, logic c);
    logic [32:0] exp;
    operand = op; kind = k; imm_mode = im; amt = a; cin = c;
    #1;
    exp = model(op, k, im, a, c);
    checks++;
    if ({cout, result} !== exp) begin
      errors++;
      $display("FAIL %s op=%h kind=%0d imm=%0b amt=%0d cin=%0b got res=%h c=%0b exp res=%h c=%0b",
               tag(k, im, a), op, k, im, a, c, result, cout, exp[31:0], exp[32]);
    end
    #1;
  endtask

  function automatic logic [31:0] pick_op(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0001;
      3: return 32'h7FFF_FFFE;
      4: return 32'hA5C3_1E69;
      5: return 32'h5555_AAAA;
      6: return 32'h1234_5678;
      default: return 32'hC001_0F0D;
    endcase
  endfunction

  initial begin
    operand = '0; kind = '0; imm_mode = 1'b0; amt = '0; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // Idle inputs: zero out, carry follows the zero carry-in (R7)
    checks++;
    if (result !== 32'h0 || cout !== 1'b0) begin
      errors++;
      $display("FAIL R7 idle got res=%h c=%0b exp res=0 c=0", result, cout);
    end
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 8; i++) begin
          // Packed amounts; odd ones carry junk in bits 7:5 (R6)
          for (int n = 0; n < 32; n++) begin
            logic [2:0] hi;
            hi = n[0] ? (3'(n >> 1) | 3'b001) : 3'b000;
            apply(pick_op(i), 2'(k), 1'b1, {hi, 5'(n)}, 1'(c));
          end
          for (int n = 0; n < 256; n++)
            apply(pick_op(i), 2'(k), 1'b0, 8'(n), 1'(c));
        end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule